// File: doc/BRIEF.md
# Virtual Address Translation and Access Check Unit

This block turns a 32-bit virtual address into a physical address for one access per clock: an instruction fetch, a data read or a data write. It first applies a fixed address-space layout, where two high windows skip the translation table entirely. Outside those windows it either strips the top three address bits, when translation is switched off, or looks the address up in a fully associative table of page entries. Each entry has its own page size, so the match is a range compare.

After a single hit the unit applies the page protection and dirty rules. It then reports either a physical address or a fault code that the exception logic can use directly as a vector offset. The code depends on the kind of fault and on whether the access was a write. The entry table comes in as a flat vector from the surrounding register file. This unit only reads that table; filling it and choosing victims happen elsewhere.

The lookup is fully combinational across all entries. The result is captured in one output register, so each request is answered on the following clock edge.

Top module: `vtlb_translate`

## Requirements
- R1: Entry i of the table occupies bits [i*56 +: 56] of `ent_tab_i`. Its fields, from bit 55 down, are: valid (55), shared (54), ASID (53:46), VPN (45:24), size code (23:22), PPN (21:3), protection (2:1) and dirty (0). Access codes are 0 read, 1 write and 2 fetch; code 3 behaves as a read.
- R2: Outputs are registered, and a request presented before a clock edge shows on `pa_o`, `ok_o` and `fault_o` after that edge. While `rst` is high all three are cleared to zero.
- R3: In privileged mode, addresses 0x80000000–0xBFFFFFFF map to the address with bits 31:29 cleared, and addresses at or above 0xE0000000 map to themselves. Neither depends on the translate-enable bit or on the table.
- R4: In user mode, an address in 0x80000000–0xBFFFFFFF or at or above 0xE4000000 gives fault 0x0E0 for a read or fetch and 0x100 for a write. User accesses to 0xE0000000–0xE3FFFFFF pass through unchanged.
- R5: With translation disabled, every address outside the windows of R3 maps to the address with bits 31:29 cleared, and no fault is raised.
- R6: An invalid entry never matches. The ASID is compared when single-virtual mode is off or the access is in user mode. The ASID is never compared for a shared entry.
- R7: Size codes 0, 1, 2 and 3 select pages of 1 KB, 4 KB, 64 KB and 1 MB. An entry matches any address inside the page that contains VPN×1024, aligned down to the page size. VPN bits below the page size are ignored.
- R8: On a clean hit, the physical address is the page-aligned value of PPN×1024, ORed with the address bits below the page size.
- R9: Two or more matching entries give fault 0x140. This takes precedence over every protection check.
- R10: No matching entry gives fault 0x040 for a read or fetch and 0x060 for a write.
- R11: A user-mode hit on an entry whose protection bit 1 is clear gives 0x0A0 for a read or fetch and 0x0C0 for a write.
- R12: Once R11 passes, a write to an entry whose protection bit 0 is clear gives 0x0C0. Otherwise, a write to an entry whose dirty bit is clear gives 0x080. Reads and fetches skip both checks.
- R13: `ok_o` is 1 exactly when `fault_o` is zero. While a fault is reported, `pa_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| va_i | input | 32 | Virtual address of the access |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| priv_i | input | 1 | Privileged mode when 1 |
| sv_mode_i | input | 1 | Single-virtual mode bit |
| xlate_en_i | input | 1 | Translation enable bit |
| asid_i | input | 8 | Current address-space identifier |
| ent_tab_i | input | NUM_ENTRIES*56 | Flattened entry table, layout as in R1 |
| pa_o | output | 32 | Physical address |
| ok_o | output | 1 | Translation succeeded |
| fault_o | output | 12 | Fault code, zero on success |

## Verification
The hardest case to reach from the ports is the combination of a genuine multiple hit with the protection checks. Entries of different sizes must overlap on the same address while both pass the valid and ASID filters. Only then can one show that 0x140 wins over a protection or dirty fault. The directed part builds this overlap by hand, placing a 1 MB page over a 4 KB page. The random part draws table entries from a small ASID pool and often copies one entry's VPN into another. It also aims most addresses at existing page bases plus an offset within the page, so hits, overlaps, ASID filtering and every fault code occur many times.

// File: rtl/vtlb_pkg.sv
`timescale 1ns/1ps
package vtlb_pkg;

    localparam int VA_W   = 32;
    localparam int ASID_W = 8;
    localparam int GRAIN  = 10;
    localparam int VPN_W  = VA_W - GRAIN;
    localparam int PPN_W  = 19;
    localparam int HI_PAD = VA_W - PPN_W - GRAIN;

    typedef struct packed {
        logic [1:0]       szc;
        logic [PPN_W-1:0] ppn;
        logic [1:0]       prot;
        logic             dirty;
    } tlb_page_t;

    typedef struct packed {
        logic              valid;
        logic              shared;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        tlb_page_t         page;
    } tlb_ent_t;

    localparam int ENT_W = $bits(tlb_ent_t);

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [11:0] {
        FLT_NONE     = 12'h000,
        FLT_MISS_RD  = 12'h040,
        FLT_MISS_WR  = 12'h060,
        FLT_FIRST_WR = 12'h080,
        FLT_PROT_RD  = 12'h0A0,
        FLT_PROT_WR  = 12'h0C0,
        FLT_AERR_RD  = 12'h0E0,
        FLT_AERR_WR  = 12'h100,
        FLT_MULTI    = 12'h140
    } fault_e;

    typedef struct packed {
        logic [VA_W-1:0] pa;
        fault_e          fault;
    } xres_t;

    // number of in-page offset bits for a size code
    function automatic int unsigned offset_bits(logic [1:0] szc);
        case (szc)
            2'd0:    return 10;
            2'd1:    return 12;
            2'd2:    return 16;
            default: return 20;
        endcase
    endfunction

    // ones over the page-number bits, zeros over the offset
    function automatic logic [VA_W-1:0] page_hi_mask(logic [1:0] szc);
        return ~((VA_W'(1) << offset_bits(szc)) - VA_W'(1));
    endfunction

    function automatic logic [VA_W-1:0] page_base(logic [VPN_W-1:0] vpn);
        return {vpn, {GRAIN{1'b0}}};
    endfunction

    function automatic logic [VA_W-1:0] frame_base(logic [PPN_W-1:0] ppn);
        return {{HI_PAD{1'b0}}, ppn, {GRAIN{1'b0}}};
    endfunction

    // cached/uncached kernel window that skips the table
    function automatic logic in_fixed_window(logic [VA_W-1:0] va);
        return va[VA_W-1 -: 2] == 2'b10;
    endfunction

    // control space at the top of the map
    function automatic logic in_ctl_space(logic [VA_W-1:0] va);
        return va[VA_W-1 -: 3] == 3'b111;
    endfunction

    // part of control space open to user mode
    function automatic logic in_user_window(logic [VA_W-1:0] va);
        return va[VA_W-1 -: 6] == 6'b111000;
    endfunction

    function automatic logic [VA_W-1:0] strip_top3(logic [VA_W-1:0] va);
        return {3'b000, va[VA_W-4:0]};
    endfunction

endpackage

// File: rtl/vtlb_match_cell.sv
`timescale 1ns/1ps
module vtlb_match_cell
    import vtlb_pkg::*;
(
    input  logic              valid_i,
    input  logic              shared_i,
    input  logic [ASID_W-1:0] ent_asid_i,
    input  logic [VPN_W-1:0]  vpn_i,
    input  logic [1:0]        szc_i,
    input  logic [VA_W-1:0]   va_i,
    input  logic [ASID_W-1:0] cur_asid_i,
    input  logic              chk_asid_i,
    output logic              hit_o
);

    logic [VA_W-1:0] hi_mask;
    logic            asid_ok;
    logic            range_ok;

    always_comb begin
        hi_mask  = page_hi_mask(szc_i);
        asid_ok  = shared_i || !chk_asid_i || (ent_asid_i == cur_asid_i);
        // same page when no page-number bit differs
        range_ok = ((va_i ^ page_base(vpn_i)) & hi_mask) == '0;
        hit_o    = valid_i && asid_ok && range_ok;
    end

endmodule

// File: rtl/vtlb_hit_merge.sv
`timescale 1ns/1ps
module vtlb_hit_merge
    import vtlb_pkg::*;
#(
    parameter int N = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    hit_i,
    input  tlb_page_t       page_i [N],
    output logic            any_o,
    output logic            multi_o,
    output tlb_page_t       sel_o
);

    localparam int CNT_W  = $clog2(N + 1);
    localparam int PAGE_W = $bits(tlb_page_t);

    logic [CNT_W-1:0]  cnt;
    logic [PAGE_W-1:0] or_tree;

    // AND-OR select: exact when at most one hit, and unused otherwise
    always_comb begin
        cnt     = '0;
        or_tree = '0;
        for (int i = 0; i < N; i++) begin
            cnt     = cnt + CNT_W'(hit_i[i]);
            or_tree = or_tree | (page_i[i] & {PAGE_W{hit_i[i]}});
        end
        any_o   = cnt != '0;
        multi_o = cnt > CNT_W'(1);
        sel_o   = or_tree;
    end

    // R9: the AND-OR select is only trusted when the vector is one-hot or empty
    a_r9_single_select: assert property (@(posedge clk) disable iff (rst)
        !multi_o |-> $onehot0(hit_i));

endmodule

// File: rtl/vtlb_perm_check.sv
`timescale 1ns/1ps
module vtlb_perm_check
    import vtlb_pkg::*;
(
    input  tlb_page_t       page_i,
    input  logic [VA_W-1:0] va_i,
    input  logic            priv_i,
    input  logic            wr_i,
    output xres_t           res_o
);

    logic [VA_W-1:0] hi_mask;

    always_comb begin
        hi_mask     = page_hi_mask(page_i.szc);
        res_o.pa    = '0;
        res_o.fault = FLT_NONE;
        if (!priv_i && !page_i.prot[1]) begin
            res_o.fault = wr_i ? FLT_PROT_WR : FLT_PROT_RD;
        end else if (wr_i && !page_i.prot[0]) begin
            res_o.fault = FLT_PROT_WR;
        end else if (wr_i && !page_i.dirty) begin
            res_o.fault = FLT_FIRST_WR;
        end else begin
            res_o.pa = (frame_base(page_i.ppn) & hi_mask) | (va_i & ~hi_mask);
        end
    end

endmodule

// File: rtl/vtlb_translate.sv
`timescale 1ns/1ps
module vtlb_translate
    import vtlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [31:0]                  va_i,
    input  logic [1:0]                   acc_i,
    input  logic                         priv_i,
    input  logic                         sv_mode_i,
    input  logic                         xlate_en_i,
    input  logic [7:0]                   asid_i,
    input  logic [NUM_ENTRIES*56-1:0]    ent_tab_i,
    output logic [31:0]                  pa_o,
    output logic                         ok_o,
    output logic [11:0]                  fault_o
);

    tlb_ent_t             ents  [NUM_ENTRIES];
    tlb_page_t            pages [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] hits;
    logic                 chk_asid;
    logic                 is_wr;
    logic                 any_hit;
    logic                 multi_hit;
    tlb_page_t            sel_page;
    xres_t                perm_res;
    xres_t                nxt;

    assign chk_asid = !sv_mode_i || !priv_i;
    assign is_wr    = acc_i == ACC_WRITE;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        assign ents[g]  = ent_tab_i[g*ENT_W +: ENT_W];
        assign pages[g] = ents[g].page;

        vtlb_match_cell u_cell (
            .valid_i    (ents[g].valid),
            .shared_i   (ents[g].shared),
            .ent_asid_i (ents[g].asid),
            .vpn_i      (ents[g].vpn),
            .szc_i      (ents[g].page.szc),
            .va_i       (va_i),
            .cur_asid_i (asid_i),
            .chk_asid_i (chk_asid),
            .hit_o      (hits[g])
        );
    end

    vtlb_hit_merge #(.N(NUM_ENTRIES)) u_merge (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (hits),
        .page_i  (pages),
        .any_o   (any_hit),
        .multi_o (multi_hit),
        .sel_o   (sel_page)
    );

    vtlb_perm_check u_perm (
        .page_i (sel_page),
        .va_i   (va_i),
        .priv_i (priv_i),
        .wr_i   (is_wr),
        .res_o  (perm_res)
    );

    // one priority chain: region rules, then enable bit, then table outcome
    always_comb begin
        nxt.pa    = '0;
        nxt.fault = FLT_NONE;
        if (in_fixed_window(va_i) || in_ctl_space(va_i)) begin
            if (!priv_i && !in_user_window(va_i)) begin
                nxt.fault = is_wr ? FLT_AERR_WR : FLT_AERR_RD;
            end else if (in_ctl_space(va_i)) begin
                nxt.pa = va_i;
            end else begin
                nxt.pa = strip_top3(va_i);
            end
        end else if (!xlate_en_i) begin
            nxt.pa = strip_top3(va_i);
        end else if (multi_hit) begin
            nxt.fault = FLT_MULTI;
        end else if (!any_hit) begin
            nxt.fault = is_wr ? FLT_MISS_WR : FLT_MISS_RD;
        end else begin
            nxt = perm_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_o    <= '0;
            ok_o    <= 1'b0;
            fault_o <= '0;
        end else begin
            pa_o    <= nxt.pa;
            ok_o    <= nxt.fault == FLT_NONE;
            fault_o <= nxt.fault;
        end
    end

    // R4: user access into the kernel window always traps with the access-typed code
    a_r4_user_aerr: assert property (@(posedge clk) disable iff (rst)
        (!priv_i && va_i[31:30] == 2'b10) |=>
            (fault_o == (($past(acc_i) == 2'd1) ? 12'h100 : 12'h0E0)));

    // R8: any successful result outside control space lies below 512 MB
    a_r8_pa_top_clear: assert property (@(posedge clk) disable iff (rst)
        (ok_o && $past(va_i[31:29]) != 3'b111) |-> (pa_o[31:29] == 3'b000));

    // R12: write-only fault codes are never produced for reads or fetches
    a_r12_write_codes: assert property (@(posedge clk) disable iff (rst)
        (fault_o == 12'h060 || fault_o == 12'h080 || fault_o == 12'h0C0 ||
         fault_o == 12'h100) |-> ($past(acc_i) == 2'd1 || fault_o == 12'h0C0));

    // R13: a reported fault carries no address
    a_r13_fault_pa_zero: assert property (@(posedge clk) disable iff (rst)
        (fault_o != 12'h000) |-> (pa_o == 32'h0 && !ok_o));

endmodule

// File: tb/test_vtlb_translate.sv
`timescale 1ns/1ps
module test_vtlb_translate;

    localparam int NE = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       va_i = '0;
    logic [1:0]        acc_i = '0;
    logic              priv_i = 1'b1;
    logic              sv_mode_i = 1'b0;
    logic              xlate_en_i = 1'b1;
    logic [7:0]        asid_i = '0;
    logic [NE*56-1:0]  ent_tab_i = '0;
    logic [31:0]       pa_o;
    logic              ok_o;
    logic [11:0]       fault_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // bench-side table, one array per field
    logic        e_v   [NE];
    logic        e_sh  [NE];
    logic [7:0]  e_asid[NE];
    logic [21:0] e_vpn [NE];
    logic [1:0]  e_sz  [NE];
    logic [18:0] e_ppn [NE];
    logic [1:0]  e_pr  [NE];
    logic        e_d   [NE];

    always #2.5 clk = ~clk;

    vtlb_translate #(.NUM_ENTRIES(NE)) i_vtlb_translate (
        .clk(clk), .rst(rst), .va_i(va_i), .acc_i(acc_i), .priv_i(priv_i),
        .sv_mode_i(sv_mode_i), .xlate_en_i(xlate_en_i), .asid_i(asid_i),
        .ent_tab_i(ent_tab_i), .pa_o(pa_o), .ok_o(ok_o), .fault_o(fault_o)
    );

    // R1 layout: valid, shared, asid, vpn, size, ppn, prot, dirty from bit 55 down
    function automatic logic [NE*56-1:0] packed_table();
        logic [NE*56-1:0] t = '0;
        for (int i = 0; i < NE; i++)
            t[i*56 +: 56] = {e_v[i], e_sh[i], e_asid[i], e_vpn[i], e_sz[i],
                             e_ppn[i], e_pr[i], e_d[i]};
        return t;
    endfunction

    function automatic longint unsigned size_bytes(logic [1:0] c);
        case (c)
            2'd0: return 64'd1024;
            2'd1: return 64'd4096;
            2'd2: return 64'd65536;
            default: return 64'd1048576;
        endcase
    endfunction

    // reference model written from the requirements, range-compare style
    function automatic void model(input logic [31:0] va, input logic [1:0] acc,
                                  input logic priv, input logic sv, input logic xen,
                                  input logic [7:0] asid,
                                  output logic [31:0] pa, output logic [11:0] flt);
        bit wr = (acc == 2'd1);
        longint unsigned sz, st, en, a;
        int nmatch = 0;
        int idx = 0;
        a = longint'(va);
        pa = '0;
        flt = '0;
        if ((va >= 32'h8000_0000 && va < 32'hC000_0000) || va >= 32'hE000_0000) begin
            if (!priv && !(va >= 32'hE000_0000 && va < 32'hE400_0000)) begin
                flt = wr ? 12'h100 : 12'h0E0;
            end else begin
                pa = (va < 32'hC000_0000) ? (va & 32'h1FFF_FFFF) : va;
            end
            return;
        end
        if (!xen) begin
            pa = va & 32'h1FFF_FFFF;
            return;
        end
        for (int i = 0; i < NE; i++) begin
            if (!e_v[i]) continue;
            if (!e_sh[i] && (!sv || !priv) && e_asid[i] != asid) continue;
            sz = size_bytes(e_sz[i]);
            st = (longint'(e_vpn[i]) << 10) & ~(sz - 1);
            en = st + sz - 1;
            if (a >= st && a <= en) begin
                nmatch++;
                idx = i;
            end
        end
        if (nmatch > 1) flt = 12'h140;
        else if (nmatch == 0) flt = wr ? 12'h060 : 12'h040;
        else if (!priv && !e_pr[idx][1]) flt = wr ? 12'h0C0 : 12'h0A0;
        else if (wr && !e_pr[idx][0]) flt = 12'h0C0;
        else if (wr && !e_d[idx]) flt = 12'h080;
        else begin
            sz = size_bytes(e_sz[idx]);
            pa = 32'(((longint'(e_ppn[idx]) << 10) & ~(sz - 1)) | (a & (sz - 1)));
        end
    endfunction

    function automatic string tag_for(logic [31:0] va, logic xen, logic [11:0] f);
        if (f == 12'h0E0 || f == 12'h100) return "R4";
        if (va[31:30] == 2'b10 || va[31:29] == 3'b111) return "R3";
        if (!xen) return "R5";
        case (f)
            12'h140: return "R9";
            12'h040, 12'h060: return "R10";
            12'h0A0: return "R11";
            12'h0C0: return "R11/R12";
            12'h080: return "R12";
            default: return "R8";
        endcase
    endfunction

    task automatic apply(input logic [31:0] va, input logic [1:0] acc, input logic priv,
                         input logic sv, input logic xen, input logic [7:0] asid,
                         input string tag);
        logic [31:0] epa;
        logic [11:0] ef;
        ent_tab_i  = packed_table();
        va_i       = va;
        acc_i      = acc;
        priv_i     = priv;
        sv_mode_i  = sv;
        xlate_en_i = xen;
        asid_i     = asid;
        model(va, acc, priv, sv, xen, asid, epa, ef);
        @(negedge clk);
        vectors++;
        if (pa_o !== epa || fault_o !== ef || ok_o !== (ef == 12'h000)) begin
            miscompares++;
            $display("FAIL %s: va=%h acc=%0d priv=%b got pa=%h fault=%h ok=%b expected pa=%h fault=%h ok=%b",
                     (tag == "") ? tag_for(va, xen, ef) : tag, va, acc, priv,
                     pa_o, fault_o, ok_o, epa, ef, (ef == 12'h000));
        end
    endtask

    task automatic check_zero(input string tag);
        vectors++;
        if (pa_o !== 32'h0 || fault_o !== 12'h0 || ok_o !== 1'b0) begin
            miscompares++;
            $display("FAIL %s: reset state got pa=%h fault=%h ok=%b expected pa=0 fault=0 ok=0",
                     tag, pa_o, fault_o, ok_o);
        end
    endtask

    task automatic set_ent(input int i, input logic v, input logic sh, input logic [7:0] asid,
                           input logic [21:0] vpn, input logic [1:0] sz, input logic [18:0] ppn,
                           input logic [1:0] pr, input logic d);
        e_v[i] = v; e_sh[i] = sh; e_asid[i] = asid; e_vpn[i] = vpn;
        e_sz[i] = sz; e_ppn[i] = ppn; e_pr[i] = pr; e_d[i] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NE; i++) set_ent(i, 0, 0, 0, 0, 0, 0, 0, 0);
        set_ent(0, 1, 0, 8'd5, 22'h01000, 2'd0, 19'h00123, 2'b11, 1);
        set_ent(1, 1, 0, 8'd5, 22'h4000C, 2'd1, 19'h70004, 2'b11, 1);
        set_ent(2, 1, 0, 8'd5, 22'h80043, 2'd2, 19'h05547, 2'b11, 1);
        set_ent(3, 1, 0, 8'd5, 22'hC0407, 2'd3, 19'h08005, 2'b11, 1);
        set_ent(4, 1, 0, 8'd9, 22'h01400, 2'd1, 19'h00400, 2'b11, 1);
        set_ent(5, 1, 1, 8'd2, 22'h01800, 2'd1, 19'h00600, 2'b11, 1);
        set_ent(6, 1, 0, 8'd5, 22'h01C00, 2'd1, 19'h00700, 2'b01, 1);
        set_ent(7, 1, 0, 8'd5, 22'h02000, 2'd1, 19'h00800, 2'b10, 1);
        ent_tab_i = packed_table();
        repeat (3) @(negedge clk);
        check_zero("R2");
        rst = 1'b0;

        // R3 privileged fixed windows, with and without translation
        apply(32'h8123_4567, 2'd0, 1, 0, 1, 8'd5, "R3");
        apply(32'hA000_0010, 2'd1, 1, 0, 1, 8'd5, "R3");
        apply(32'hFF00_0020, 2'd2, 1, 0, 0, 8'd5, "R3");
        apply(32'hBFFF_FFFF, 2'd0, 1, 0, 0, 8'd5, "R3");
        // R4 user address errors and the open user window
        apply(32'h8000_0000, 2'd0, 0, 0, 1, 8'd5, "R4");
        apply(32'hBFFF_FFFC, 2'd1, 0, 0, 1, 8'd5, "R4");
        apply(32'hE400_0000, 2'd2, 0, 0, 1, 8'd5, "R4");
        apply(32'hE3FF_FFF0, 2'd1, 0, 0, 1, 8'd5, "R4");
        // R5 translation disabled
        apply(32'h7654_3210, 2'd1, 0, 0, 0, 8'd5, "R5");
        apply(32'hC000_1234, 2'd0, 1, 0, 0, 8'd5, "R5");
        // R1 R7 R8 page sizes and boundaries
        apply(32'h0040_03FF, 2'd0, 1, 0, 1, 8'd5, "R1");
        apply(32'h0040_0400, 2'd0, 1, 0, 1, 8'd5, "R7");
        apply(32'h1000_3ABC, 2'd1, 1, 0, 1, 8'd5, "R8");
        apply(32'h2001_FFFF, 2'd0, 1, 0, 1, 8'd5, "R7");
        apply(32'h2002_0000, 2'd0, 1, 0, 1, 8'd5, "R7");
        apply(32'h301F_FFFF, 2'd2, 1, 0, 1, 8'd5, "R8");
        // R6 ASID filtering
        apply(32'h0050_0010, 2'd0, 1, 0, 1, 8'd5, "R6");
        apply(32'h0050_0010, 2'd0, 1, 0, 1, 8'd9, "R6");
        apply(32'h0050_0010, 2'd0, 1, 1, 1, 8'd5, "R6");
        apply(32'h0050_0010, 2'd0, 0, 1, 1, 8'd5, "R6");
        apply(32'h0060_0ABC, 2'd0, 0, 0, 1, 8'd5, "R6");
        // R11 user protection
        apply(32'h0070_0004, 2'd0, 0, 0, 1, 8'd5, "R11");
        apply(32'h0070_0004, 2'd1, 0, 0, 1, 8'd5, "R11");
        apply(32'h0070_0004, 2'd2, 0, 0, 1, 8'd5, "R11");
        apply(32'h0070_0004, 2'd0, 1, 0, 1, 8'd5, "R11");
        // R12 write protection and first write
        apply(32'h0080_0100, 2'd1, 1, 0, 1, 8'd5, "R12");
        apply(32'h0080_0100, 2'd0, 1, 0, 1, 8'd5, "R12");
        set_ent(7, 1, 0, 8'd5, 22'h02000, 2'd1, 19'h00800, 2'b11, 0);
        apply(32'h0080_0100, 2'd1, 1, 0, 1, 8'd5, "R12");
        apply(32'h0080_0100, 2'd3, 1, 0, 1, 8'd5, "R12");
        // R10 misses through an invalid entry
        e_v[0] = 1'b0;
        apply(32'h0040_0000, 2'd0, 1, 0, 1, 8'd5, "R10");
        apply(32'h0040_0000, 2'd1, 1, 0, 1, 8'd5, "R10");
        apply(32'h0040_0000, 2'd2, 1, 0, 1, 8'd5, "R10");
        // R9 overlap of a 1 MB page over a 4 KB page, and a dirty-clear overlap
        set_ent(4, 1, 0, 8'd5, 22'h40000, 2'd3, 19'h00400, 2'b01, 0);
        apply(32'h1000_3000, 2'd0, 1, 0, 1, 8'd5, "R9");
        apply(32'h1000_3000, 2'd1, 0, 0, 1, 8'd5, "R9");
        // R2 reset in the middle of a run clears the outputs
        apply(32'h1000_3ABC, 2'd0, 1, 0, 0, 8'd5, "R2");
        rst = 1'b1;
        @(negedge clk);
        check_zero("R2");
        rst = 1'b0;

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] va;
            logic [1:0]  acc;
            if (n % 16 == 0) begin
                for (int i = 0; i < NE; i++) begin
                    logic [21:0] vpn = 22'($urandom);
                    if ($urandom % 4 == 0) vpn[21:19] = 3'b110;
                    else vpn[21] = 1'b0;
                    set_ent(i, ($urandom % 8) != 0, ($urandom % 4) == 0, 8'($urandom % 4),
                            vpn, 2'($urandom), 19'($urandom), 2'($urandom), 1'($urandom));
                end
                if ($urandom % 3 == 0) begin
                    e_vpn[1] = e_vpn[0];
                    e_v[0] = 1'b1;
                    e_v[1] = 1'b1;
                end
            end
            if ($urandom % 10 < 7) begin
                int k = int'($urandom % NE);
                va = {e_vpn[k], 10'b0} + 32'($urandom % 32'(size_bytes(e_sz[k])));
            end else begin
                va = $urandom;
            end
            acc = 2'($urandom);
            apply(va, acc, 1'($urandom), 1'($urandom), ($urandom % 8) != 0,
                  8'($urandom % 4), "");
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule